// File: doc/BRIEF.md
# Multi-Stage Streaming Channel Buffer

This block is a chain of register slices placed in a streaming data channel. It cuts long timing paths and adds elasticity. A parameter sets the number of slices. Each slice takes part in a valid/ready handshake at full rate. It can hand a word downstream in the same cycle that it accepts a new one, and it keeps a second word in a side register when its consumer stalls. No word is ever lost or repeated.

Each end of the chain can use one of two kinds of signaling, chosen by parameter:

- **Handshake:** valid and ready.
- **Pull:** an empty flag and a read enable. The producer or consumer shows the head word whenever it is not empty, and a read enable in a cycle removes that word.

Small combinational adapters sit at a pull-style end and turn that end into the handshake that the slice chain uses. Both sets of control pins are always present on the top module. The set that the configured mode does not use is ignored.

Top module: `chanbuf_pipe`

## Requirements
- R1: `STAGES` (default 1, at least 1) sets the number of slices. With handshake output and `out_ready` held high, a word accepted at clock edge k shows on `out_valid`/`out_data` right after edge k+STAGES-1. That is, it appears after exactly STAGES edges.
- R2: While `rst_n` is low, and at once when it falls, every slice is empty: `out_valid`=0, `out_empty`=1 and `in_ready`=1.
- R3: Under any pattern of producer gaps and consumer stalls, in any mode pairing, words leave in the order they entered. None is dropped and none is duplicated.
- R4: With the consumer always ready, the buffer accepts and delivers one word in every clock cycle. `in_ready` never drops.
- R5: While `out_valid`=1 and `out_ready`=0 (handshake output), `out_valid` and `out_data` hold their values.
- R6: In pull input mode, the internal input valid is the inverse of `in_empty`. `in_rd_en` = !`in_empty` AND first-slice ready, and `in_valid` is ignored. In handshake input mode, `in_rd_en` stays 0 and `in_empty` is ignored. `in_ready` always reports first-slice ready.
- R7: `out_empty` is always the inverse of `out_valid`. In pull output mode, `out_rd_en` is the ready of the last slice and `out_ready` is ignored. In handshake output mode, `out_ready` is that ready and `out_rd_en` is ignored.
- R8: With the output stalled, the buffer holds exactly 2×STAGES words before `in_ready` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| in_valid | input | 1 | Producer word valid (handshake input mode) |
| in_empty | input | 1 | Producer has no word (pull input mode) |
| in_ready | output | 1 | First slice can accept a word |
| in_rd_en | output | 1 | Pops the producer head word (pull input mode, else 0) |
| in_data | input | DATA_W | Producer word |
| out_valid | output | 1 | Last slice holds a word |
| out_empty | output | 1 | Inverse of out_valid |
| out_ready | input | 1 | Consumer accepts the word (handshake output mode) |
| out_rd_en | input | 1 | Consumer pops the word (pull output mode) |
| out_data | output | DATA_W | Word at the head of the buffer |

## Verification
- **Single word, consumer always ready:** measures the edge-exact latency of the chain.
- **Unbroken stream:** separates a full-rate slice from one that inserts bubbles.
- **Stalled output with the producer still pushing:** shows whether the side registers fill to exactly twice the stage count, with the head word held steady, and whether the words drain in order afterwards.
- **Random gaps and stalls on all four mode pairings, against a scoreboard queue:** catches loss, duplication or reordering at the adapters and inside the slices.
- **Targeted cases:** show that the unused control pins of each mode have no effect.

// File: rtl/chanbuf_pkg.sv
package chanbuf_pkg;
  // Signaling style of one end of the channel
  typedef enum logic {
    SIG_HANDSHAKE = 1'b0,   // valid / ready
    SIG_PULL      = 1'b1    // empty flag / read enable, head word always visible
  } sig_mode_e;
endpackage

// File: rtl/chanbuf_slice.sv
// Full-rate valid/ready register slice with a one-word side register.
module chanbuf_slice #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  output logic              in_rdy,
  input  logic [DATA_W-1:0] in_dat,
  output logic              out_vld,
  input  logic              out_rdy,
  output logic [DATA_W-1:0] out_dat
);
  logic              m_vld_q, m_vld_d;
  logic [DATA_W-1:0] m_dat_q, m_dat_d;
  logic              s_vld_q, s_vld_d;
  logic [DATA_W-1:0] s_dat_q, s_dat_d;
  logic              main_open;
  logic              m_dat_en, s_dat_en;

  // Next-state logic
  always_comb begin
    main_open = out_rdy | ~m_vld_q;
    m_vld_d   = m_vld_q;
    m_dat_d   = m_dat_q;
    s_vld_d   = s_vld_q;
    s_dat_d   = s_dat_q;
    m_dat_en  = 1'b0;
    s_dat_en  = 1'b0;
    if (main_open) begin
      if (s_vld_q) begin
        m_vld_d  = 1'b1;
        m_dat_d  = s_dat_q;
        m_dat_en = 1'b1;
        s_vld_d  = 1'b0;
      end else begin
        m_vld_d  = in_vld;
        m_dat_d  = in_dat;
        m_dat_en = in_vld;
      end
    end else if (in_vld && !s_vld_q) begin
      s_vld_d  = 1'b1;
      s_dat_d  = in_dat;
      s_dat_en = 1'b1;
    end
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_vld_q <= 1'b0;
      s_vld_q <= 1'b0;
    end else begin
      m_vld_q <= m_vld_d;
      s_vld_q <= s_vld_d;
    end
  end

  // Data registers with explicit clock enables
  always_ff @(posedge clk) begin
    if (m_dat_en) m_dat_q <= m_dat_d;
    if (s_dat_en) s_dat_q <= s_dat_d;
  end

  assign in_rdy  = ~s_vld_q;
  assign out_vld = m_vld_q;
  assign out_dat = m_dat_q;

  // R5
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld && !out_rdy |=> out_vld && $stable(out_dat));
  // R8
  side_implies_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_rdy |-> out_vld);
  // R3
  no_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld && in_rdy && out_vld && !out_rdy |=> !in_rdy);
endmodule

// File: rtl/chanbuf_src_adapt.sv
// Input-end adapter: turns pull signaling into a valid/ready handshake.
module chanbuf_src_adapt
  import chanbuf_pkg::*;
#(
  parameter sig_mode_e MODE = SIG_HANDSHAKE
) (
  input  logic up_valid,
  input  logic up_empty,
  output logic up_rd_en,
  output logic int_vld,
  input  logic int_rdy
);
  logic unused_src;

  generate
    if (MODE == SIG_PULL) begin : g_pull
      assign int_vld    = ~up_empty;
      assign up_rd_en   = int_vld & int_rdy;
      assign unused_src = up_valid;
    end else begin : g_hs
      assign int_vld    = up_valid;
      assign up_rd_en   = 1'b0;
      assign unused_src = up_empty ^ int_rdy;
    end
  endgenerate
endmodule

// File: rtl/chanbuf_snk_adapt.sv
// Output-end adapter: turns the last slice's handshake into the selected signaling.
module chanbuf_snk_adapt
  import chanbuf_pkg::*;
#(
  parameter sig_mode_e MODE = SIG_HANDSHAKE
) (
  input  logic last_vld,
  output logic last_rdy,
  input  logic dn_ready,
  input  logic dn_rd_en,
  output logic dn_empty
);
  logic unused_snk;

  assign dn_empty = ~last_vld;

  generate
    if (MODE == SIG_PULL) begin : g_pull
      assign last_rdy   = dn_rd_en;
      assign unused_snk = dn_ready;
    end else begin : g_hs
      assign last_rdy   = dn_ready;
      assign unused_snk = dn_rd_en;
    end
  endgenerate
endmodule

// File: rtl/chanbuf_pipe.sv
module chanbuf_pipe
  import chanbuf_pkg::*;
#(
  parameter int        DATA_W   = 32,
  parameter int        STAGES   = 1,
  parameter sig_mode_e IN_MODE  = SIG_HANDSHAKE,
  parameter sig_mode_e OUT_MODE = SIG_HANDSHAKE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_empty,
  output logic              in_ready,
  output logic              in_rd_en,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic              out_empty,
  input  logic              out_ready,
  input  logic              out_rd_en,
  output logic [DATA_W-1:0] out_data
);
  localparam int LINKS = STAGES + 1;

  logic [LINKS-1:0]  lnk_vld;
  logic [LINKS-1:0]  lnk_rdy;
  logic [DATA_W-1:0] lnk_dat [LINKS];

  generate
    if (STAGES < 1) begin : g_bad_cfg
      $error("chanbuf_pipe: STAGES must be at least 1");
    end
  endgenerate

  chanbuf_src_adapt #(.MODE(IN_MODE)) u_src (
    .up_valid (in_valid),
    .up_empty (in_empty),
    .up_rd_en (in_rd_en),
    .int_vld  (lnk_vld[0]),
    .int_rdy  (lnk_rdy[0])
  );
  assign lnk_dat[0] = in_data;
  assign in_ready   = lnk_rdy[0];

  // Slices in series: link i feeds slice i, which drives link i+1
  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      chanbuf_slice #(.DATA_W(DATA_W)) u_slice (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (lnk_vld[i]),
        .in_rdy  (lnk_rdy[i]),
        .in_dat  (lnk_dat[i]),
        .out_vld (lnk_vld[i+1]),
        .out_rdy (lnk_rdy[i+1]),
        .out_dat (lnk_dat[i+1])
      );
    end
  endgenerate

  chanbuf_snk_adapt #(.MODE(OUT_MODE)) u_snk (
    .last_vld (lnk_vld[STAGES]),
    .last_rdy (lnk_rdy[STAGES]),
    .dn_ready (out_ready),
    .dn_rd_en (out_rd_en),
    .dn_empty (out_empty)
  );
  assign out_valid = lnk_vld[STAGES];
  assign out_data  = lnk_dat[STAGES];

  // R7
  pull_head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (OUT_MODE == SIG_PULL) && !out_empty && !out_rd_en |=> !out_empty && $stable(out_data));
  // R6
  pull_in_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (IN_MODE == SIG_PULL) && in_empty |-> !in_rd_en);
endmodule

// File: tb/chanbuf_pipe_tb.sv
`timescale 1ns/1ps
module chanbuf_pipe_tb;
  import chanbuf_pkg::*;

  localparam int DW = 16;
  localparam int NS = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic [3:0] in_valid, in_empty, out_ready, out_rd_en;
  logic [3:0] in_ready, in_rd_en, out_valid, out_empty;
  logic [DW-1:0] in_data  [4];
  logic [DW-1:0] out_data [4];

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  // index k: bit0 = pull input, bit1 = pull output; g_dut[0] is plain handshake
  generate
    for (genvar k = 0; k < 4; k++) begin : g_dut
      chanbuf_pipe #(
        .DATA_W   (DW),
        .STAGES   (NS),
        .IN_MODE  (sig_mode_e'(k % 2)),
        .OUT_MODE (sig_mode_e'(k / 2))
      ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid[k]),
        .in_empty  (in_empty[k]),
        .in_ready  (in_ready[k]),
        .in_rd_en  (in_rd_en[k]),
        .in_data   (in_data[k]),
        .out_valid (out_valid[k]),
        .out_empty (out_empty[k]),
        .out_ready (out_ready[k]),
        .out_rd_en (out_rd_en[k]),
        .out_data  (out_data[k])
      );
    end
  endgenerate

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic idle_all();
    in_valid  = '0;
    in_empty  = '1;
    out_ready = '0;
    out_rd_en = '0;
    for (int k = 0; k < 4; k++) in_data[k] = '0;
  endtask

  // R2: reset state
  task automatic t_reset();
    idle_all();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    chk(out_valid == 4'h0, "R2 out_valid in reset", int'(out_valid), 0);
    chk(out_empty == 4'hF, "R2 out_empty in reset", int'(out_empty), 15);
    chk(in_ready  == 4'hF, "R2 in_ready in reset", int'(in_ready), 15);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // R1: latency of exactly NS edges
  task automatic t_latency();
    out_ready[0] = 1'b1;
    @(negedge clk);
    in_valid[0] = 1'b1;
    in_data[0]  = 16'hA5A5;
    #1 chk(in_ready[0] == 1'b1, "R1 accept", int'(in_ready[0]), 1);
    for (int e = 1; e <= NS; e++) begin
      @(negedge clk);
      in_valid[0] = 1'b0;
      #1;
      if (e < NS) chk(out_valid[0] == 1'b0, "R1 early out", int'(out_valid[0]), 0);
      else begin
        chk(out_valid[0] == 1'b1, "R1 out after NS edges", int'(out_valid[0]), 1);
        chk(out_data[0] == 16'hA5A5, "R1 data", int'(out_data[0]), 'hA5A5);
      end
    end
    @(negedge clk);
    out_ready[0] = 1'b0;
  endtask

  // R4: full throughput
  task automatic t_throughput();
    out_ready[0] = 1'b1;
    for (int i = 0; i < 20 + NS; i++) begin
      @(negedge clk);
      in_valid[0] = (i < 20);
      in_data[0]  = DW'(100 + i);
      #1;
      if (i < 20) chk(in_ready[0] == 1'b1, "R4 in_ready", int'(in_ready[0]), 1);
      if (i >= NS) begin
        chk(out_valid[0] == 1'b1, "R4 out_valid every cycle", int'(out_valid[0]), 1);
        chk(out_data[0] == DW'(100 + i - NS), "R4 data order", int'(out_data[0]), 100 + i - NS);
      end
    end
    @(negedge clk);
    in_valid[0] = 1'b0;
    out_ready[0] = 1'b0;
  endtask

  // R8 capacity, R5 hold, then in-order drain
  task automatic t_stall();
    int acc;
    int got;
    acc = 0;
    got = 0;
    out_ready[0] = 1'b0;
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      in_valid[0] = 1'b1;
      in_data[0]  = DW'(200 + acc);
      #1;
      if (in_ready[0]) acc++;
    end
    @(negedge clk);
    in_valid[0] = 1'b0;
    #1;
    chk(acc == 2 * NS, "R8 words held while stalled", acc, 2 * NS);
    chk(in_ready[0] == 1'b0, "R8 in_ready low when full", int'(in_ready[0]), 0);
    chk(out_valid[0] == 1'b1, "R5 out_valid held", int'(out_valid[0]), 1);
    chk(out_data[0] == DW'(200), "R5 head held", int'(out_data[0]), 200);
    for (int c = 0; c < 4 * NS; c++) begin
      @(negedge clk);
      out_ready[0] = 1'b1;
      #1;
      if (out_valid[0]) begin
        chk(out_data[0] == DW'(200 + got), "R8 drain order", int'(out_data[0]), 200 + got);
        got++;
      end
    end
    chk(got == 2 * NS, "R8 drain count", got, 2 * NS);
    @(negedge clk);
    out_ready[0] = 1'b0;
  endtask

  // R2: asynchronous clear of loaded slices
  task automatic t_async_reset();
    out_ready[0] = 1'b0;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      in_valid[0] = 1'b1;
      in_data[0]  = DW'(300 + c);
    end
    @(negedge clk);
    in_valid[0] = 1'b0;
    #1 chk(out_valid[0] == 1'b1, "R2 loaded before reset", int'(out_valid[0]), 1);
    rst_n = 1'b0;
    #1;
    chk(out_valid[0] == 1'b0, "R2 async clear out_valid", int'(out_valid[0]), 0);
    chk(in_ready[0] == 1'b1, "R2 async clear in_ready", int'(in_ready[0]), 1);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // R6: pull input adapter and ignored pins
  task automatic t_pull_in();
    out_ready[1] = 1'b1;
    in_valid[1]  = 1'b1;   // ignored in pull input mode
    in_empty[1]  = 1'b1;
    in_valid[0]  = 1'b1;   // handshake input: rd_en stays 0
    in_empty[0]  = 1'b0;   // ignored in handshake input mode
    in_data[0]   = 16'h0042;
    out_ready[0] = 1'b1;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      #1;
      chk(in_rd_en[1] == 1'b0, "R6 no pop when empty", int'(in_rd_en[1]), 0);
      chk(in_rd_en[0] == 1'b0, "R6 rd_en idle in handshake mode", int'(in_rd_en[0]), 0);
    end
    chk(out_valid[1] == 1'b0, "R6 in_valid ignored in pull mode", int'(out_valid[1]), 0);
    @(negedge clk);
    in_valid[0]  = 1'b0;
    in_empty[0]  = 1'b1;
    in_valid[1]  = 1'b0;
    in_empty[1]  = 1'b0;
    in_data[1]   = 16'd77;
    #1 chk(in_rd_en[1] == 1'b1, "R6 pop when not empty and ready", int'(in_rd_en[1]), 1);
    @(negedge clk);
    in_empty[1] = 1'b1;
    repeat (NS - 1) @(negedge clk);
    #1;
    chk(out_valid[1] == 1'b1, "R6 word delivered", int'(out_valid[1]), 1);
    chk(out_data[1] == 16'd77, "R6 word value", int'(out_data[1]), 77);
    @(negedge clk);
    out_ready = '0;
    @(negedge clk);
    out_ready[0] = 1'b1;
    repeat (NS + 2) @(negedge clk);
    out_ready[0] = 1'b0;
  endtask

  // R7: pull output adapter; out_ready ignored
  task automatic t_pull_out();
    out_ready[2] = 1'b1;   // ignored in pull output mode
    out_rd_en[2] = 1'b0;
    @(negedge clk);
    in_valid[2] = 1'b1;
    in_data[2]  = 16'd55;
    @(negedge clk);
    in_valid[2] = 1'b0;
    repeat (NS + 2) @(negedge clk);
    #1;
    chk(out_empty[2] == 1'b0, "R7 word stays despite out_ready", int'(out_empty[2]), 0);
    chk(out_data[2] == 16'd55, "R7 head word", int'(out_data[2]), 55);
    chk(out_empty[2] == !out_valid[2], "R7 empty is not valid", int'(out_empty[2]), int'(!out_valid[2]));
    @(negedge clk);
    out_rd_en[2] = 1'b1;
    @(negedge clk);
    out_rd_en[2] = 1'b0;
    #1 chk(out_empty[2] == 1'b1, "R7 popped by rd_en", int'(out_empty[2]), 1);
    out_ready[2] = 1'b0;
  endtask

  // R3: random gaps and stalls, scoreboard check
  task automatic t_random(input int k);
    logic [DW-1:0] sb[$];
    logic [DW-1:0] exp_w;
    int  sent, rcvd, nxt, cyc;
    bit  pend, acc, dlv, pin, pout;
    sent = 0; rcvd = 0; nxt = 1000 * (k + 1); cyc = 0; pend = 0;
    pin  = (k % 2) == 1;
    pout = (k / 2) == 1;
    while (rcvd < 60 && cyc < 3000) begin
      @(negedge clk);
      cyc++;
      if (pin) begin
        in_empty[k] = !(sent < 60 && ($urandom % 4) != 0);
      end else begin
        if (!pend && sent < 60 && ($urandom % 4) != 0) pend = 1'b1;
        in_valid[k] = pend;
      end
      in_data[k] = DW'(nxt);
      if (pout) out_rd_en[k] = !out_empty[k] && (($urandom % 3) != 0);
      else      out_ready[k] = (($urandom % 3) != 0);
      #1;
      acc = pin ? in_rd_en[k] : (in_valid[k] & in_ready[k]);
      dlv = pout ? (out_rd_en[k] & !out_empty[k]) : (out_valid[k] & out_ready[k]);
      if (dlv) begin
        if (sb.size() == 0) chk(1'b0, "R3 delivery from empty scoreboard", int'(out_data[k]), -1);
        else begin
          exp_w = sb.pop_front();
          chk(out_data[k] == exp_w, "R3 order", int'(out_data[k]), int'(exp_w));
        end
        rcvd++;
      end
      if (acc) begin
        sb.push_back(DW'(nxt));
        nxt++;
        sent++;
        pend = 1'b0;
      end
    end
    chk(rcvd == 60, "R3 all words delivered", rcvd, 60);
    @(negedge clk);
    in_valid[k]  = 1'b0;
    in_empty[k]  = 1'b1;
    out_ready[k] = 1'b0;
    out_rd_en[k] = 1'b0;
    #1 chk(out_valid[k] == 1'b0, "R3 nothing extra left", int'(out_valid[k]), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    t_reset();
    t_latency();
    t_throughput();
    t_stall();
    t_async_reset();
    t_pull_in();
    t_pull_out();
    for (int k = 0; k < 4; k++) t_random(k);
    finish_run();
  end
endmodule